// File: doc/BRIEF.md
# Asynchronous Bus Glue with Acknowledge Delay

This block sits between a microprocessor's asynchronous bus and its memories and peripherals. It splits the address space into eight pages using the top three page-address bits. Page zero maps to ROM, so the vector area at address zero is always answered by ROM. Pages one and two map to SRAM, page three maps to the serial I/O device, and the remaining pages are left unused. Each chip select is active low. A select can assert only while the address strobe is low.

The block also drives byte-lane read and write enables for the memories. It builds them from the two data strobes and the read/write line. It returns the data-transfer acknowledge after a fixed number of clock edges, set by a parameter. The acknowledge drops back the moment the processor releases its strobes, so a new cycle always waits the full delay again.

Top module: `bus_glue_top`

## Requirements
- R1: With `asN` low and `pageAddr` equal to 0, `romSelN` is low and `ramSelN` and `ioSelN` are high. This also holds at address zero.
- R2: With `asN` low, pages 1 and 2 drive only `ramSelN` low, and page 3 drives only `ioSelN` low. Pages 4 to 7 leave all three selects high. At most one select is low at any time.
- R3: While `asN` is high, `romSelN`, `ramSelN` and `ioSelN` are all high, whatever the page.
- R4: `rdLoN` equals `ldsN | ~rdWrN` and `rdHiN` equals `udsN | ~rdWrN`. `rdWrN` is 1 for a read and 0 for a write.
- R5: `wrLoN` equals `ldsN | rdWrN` and `wrHiN` equals `udsN | rdWrN`. Both write enables stay high while both data strobes are high. A read enable and a write enable of the same lane are never low together.
- R6: The start condition is `udsN` low, or `ldsN` low, or `asN` and `rdWrN` both low. While it holds, `dtackN` goes low on the (ACK_DELAY+1)-th rising `clk` edge and not before. With ACK_DELAY of 0, that is the first edge.
- R7: `dtackN` returns high in the same instant the start condition goes away, with no clock edge needed. The next start waits the full delay again.
- R8: A write cycle with `asN` and `rdWrN` low starts the delay even while both data strobes are still high.
- R9: When `pageAddr` is 4 to 7, `dtackN` stays high no matter how long the start condition lasts.
- R10: After reset, `dtackN` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that times the acknowledge delay |
| rstN | input | 1 | Active-low reset of the delay counter |
| pageAddr | input | 3 | Top three page-address bits |
| asN | input | 1 | Address strobe, active low |
| udsN | input | 1 | Upper data strobe, active low |
| ldsN | input | 1 | Lower data strobe, active low |
| rdWrN | input | 1 | 1 for read, 0 for write |
| romSelN | output | 1 | ROM chip select, active low |
| ramSelN | output | 1 | SRAM chip select, active low |
| ioSelN | output | 1 | Serial I/O chip select, active low |
| rdLoN | output | 1 | Lower-lane output enable, active low |
| rdHiN | output | 1 | Upper-lane output enable, active low |
| wrLoN | output | 1 | Lower-lane write enable, active low |
| wrHiN | output | 1 | Upper-lane write enable, active low |
| dtackN | output | 1 | Data-transfer acknowledge, active low |

## Verification
The bench counts edges around the acknowledge. A delay counter that is off by one would show a low `dtackN` one edge early or late, so a second instance with a delay of zero is checked at the first edge. After the strobes release, `dtackN` is sampled again before any edge and must already be high. A design that clears only on the clock would be caught there, and so would one that keeps its count into the next cycle. The bench also runs a write cycle with the data strobes held high, to catch a start condition that ignores the early write term. It walks all eight pages and all lane and direction combinations, which catches swapped lanes or an inverted read/write line. It holds a reserved-page access for many edges to show that the acknowledge never arrives.

// File: rtl/bus_glue_pkg.sv
package bus_glue_pkg;

  localparam int PageW = 3;
  localparam int LaneN = 2;

  localparam logic [PageW-1:0] PageRom  = 3'd0;
  localparam logic [PageW-1:0] PageRamA = 3'd1;
  localparam logic [PageW-1:0] PageRamB = 3'd2;
  localparam logic [PageW-1:0] PageIo   = 3'd3;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_ROM  = 2'd1,
    TGT_RAM  = 2'd2,
    TGT_IO   = 2'd3
  } target_e;

  // Strobes handed from control to datapath, all active high.
  typedef struct packed {
    logic             romAct;
    logic             ramAct;
    logic             ioAct;
    logic [LaneN-1:0] laneAct;   // [0] lower lane, [1] upper lane
    logic             readCyc;
    logic             ackGo;
  } glue_strobes_t;

endpackage

// File: rtl/bus_glue_ctrl.sv
module bus_glue_ctrl
  import bus_glue_pkg::*;
#(
  parameter int ACK_DELAY = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PageW-1:0] pageAddr,
  input  logic             asN,
  input  logic             udsN,
  input  logic             ldsN,
  input  logic             rdWrN,
  output glue_strobes_t    strobes
);

  localparam int CntW = (ACK_DELAY < 1) ? 1 : $clog2(ACK_DELAY + 1);
  localparam logic [CntW-1:0] LastCnt = CntW'(ACK_DELAY);

  target_e       target;
  logic          reservedPage;
  logic          startCond;
  logic [CntW-1:0] edgeCnt;
  logic          delayDone;

  // Page decode
  always_comb begin
    unique case (pageAddr)
      PageRom:            target = TGT_ROM;
      PageRamA, PageRamB: target = TGT_RAM;
      PageIo:             target = TGT_IO;
      default:            target = TGT_NONE;
    endcase
  end

  assign reservedPage = (target == TGT_NONE);

  // Cycle start: any data strobe, or an early write with address valid
  assign startCond = ~udsN | ~ldsN | (~asN & ~rdWrN);

  // Delay counter; cleared whenever the start condition is absent
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeCnt   <= '0;
      delayDone <= 1'b0;
    end else if (!startCond) begin
      edgeCnt   <= '0;
      delayDone <= 1'b0;
    end else if (edgeCnt == LastCnt) begin
      delayDone <= 1'b1;
    end else begin
      edgeCnt <= edgeCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.romAct     = ~asN & (target == TGT_ROM);
    strobes.ramAct     = ~asN & (target == TGT_RAM);
    strobes.ioAct      = ~asN & (target == TGT_IO);
    strobes.laneAct[0] = ~ldsN;
    strobes.laneAct[1] = ~udsN;
    strobes.readCyc    = rdWrN;
    // Gated by the live condition so the acknowledge releases without a clock
    strobes.ackGo      = startCond & delayDone & ~reservedPage;
  end

endmodule

// File: rtl/bus_glue_datapath.sv
module bus_glue_datapath
  import bus_glue_pkg::*;
(
  input  glue_strobes_t    strobes,
  output logic             romSelN,
  output logic             ramSelN,
  output logic             ioSelN,
  output logic [LaneN-1:0] rdLaneN,
  output logic [LaneN-1:0] wrLaneN,
  output logic             dtackN
);

  assign romSelN = ~strobes.romAct;
  assign ramSelN = ~strobes.ramAct;
  assign ioSelN  = ~strobes.ioAct;
  assign dtackN  = ~strobes.ackGo;

  for (genvar ln = 0; ln < LaneN; ln++) begin : gLane
    assign rdLaneN[ln] = ~(strobes.laneAct[ln] &  strobes.readCyc);
    assign wrLaneN[ln] = ~(strobes.laneAct[ln] & ~strobes.readCyc);
  end

endmodule

// File: rtl/bus_glue_top.sv
module bus_glue_top
  import bus_glue_pkg::*;
#(
  parameter int ACK_DELAY = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] pageAddr,
  input  logic       asN,
  input  logic       udsN,
  input  logic       ldsN,
  input  logic       rdWrN,
  output logic       romSelN,
  output logic       ramSelN,
  output logic       ioSelN,
  output logic       rdLoN,
  output logic       rdHiN,
  output logic       wrLoN,
  output logic       wrHiN,
  output logic       dtackN
);

  glue_strobes_t    strobes;
  logic [LaneN-1:0] rdLaneN;
  logic [LaneN-1:0] wrLaneN;

  bus_glue_ctrl #(.ACK_DELAY(ACK_DELAY)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .pageAddr (pageAddr),
    .asN      (asN),
    .udsN     (udsN),
    .ldsN     (ldsN),
    .rdWrN    (rdWrN),
    .strobes  (strobes)
  );

  bus_glue_datapath dp_i (
    .strobes  (strobes),
    .romSelN  (romSelN),
    .ramSelN  (ramSelN),
    .ioSelN   (ioSelN),
    .rdLaneN  (rdLaneN),
    .wrLaneN  (wrLaneN),
    .dtackN   (dtackN)
  );

  assign rdLoN = rdLaneN[0];
  assign rdHiN = rdLaneN[1];
  assign wrLoN = wrLaneN[0];
  assign wrHiN = wrLaneN[1];

endmodule

// File: rtl/bus_glue_checker.sv
module bus_glue_checker (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] pageAddr,
  input logic       asN,
  input logic       udsN,
  input logic       ldsN,
  input logic       rdWrN,
  input logic       romSelN,
  input logic       ramSelN,
  input logic       ioSelN,
  input logic       rdLoN,
  input logic       rdHiN,
  input logic       wrLoN,
  input logic       wrHiN,
  input logic       dtackN
);

  logic busy;
  assign busy = ~udsN | ~ldsN | (~asN & ~rdWrN);

  assert_one_select_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({~romSelN, ~ramSelN, ~ioSelN}));

  assert_idle_selects_R3: assert property (@(posedge clk) disable iff (!rstN)
    asN |-> (romSelN && ramSelN && ioSelN));

  assert_lane_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdLoN && !wrLoN) && !(!rdHiN && !wrHiN));

  assert_ack_waits_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dtackN) |-> $past(busy));

  assert_ack_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> dtackN);

  assert_reserved_stall_R9: assert property (@(posedge clk) disable iff (!rstN)
    pageAddr[2] |-> dtackN);

endmodule

bind bus_glue_top bus_glue_checker chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .pageAddr (pageAddr),
  .asN      (asN),
  .udsN     (udsN),
  .ldsN     (ldsN),
  .rdWrN    (rdWrN),
  .romSelN  (romSelN),
  .ramSelN  (ramSelN),
  .ioSelN   (ioSelN),
  .rdLoN    (rdLoN),
  .rdHiN    (rdHiN),
  .wrLoN    (wrLoN),
  .wrHiN    (wrHiN),
  .dtackN   (dtackN)
);

// File: tb/bus_glue_top_tb_top.sv
module bus_glue_top_tb_top;

  localparam int Delay = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] pageAddr = 3'd0;
  logic       asN = 1'b1;
  logic       udsN = 1'b1;
  logic       ldsN = 1'b1;
  logic       rdWrN = 1'b1;

  logic romSelN, ramSelN, ioSelN, rdLoN, rdHiN, wrLoN, wrHiN, dtackN;
  logic romSel0N, ramSel0N, ioSel0N, rdLo0N, rdHi0N, wrLo0N, wrHi0N, dtack0N;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bus_glue_top #(.ACK_DELAY(Delay)) dut_i (
    .clk(clk), .rstN(rstN), .pageAddr(pageAddr), .asN(asN), .udsN(udsN),
    .ldsN(ldsN), .rdWrN(rdWrN), .romSelN(romSelN), .ramSelN(ramSelN),
    .ioSelN(ioSelN), .rdLoN(rdLoN), .rdHiN(rdHiN), .wrLoN(wrLoN),
    .wrHiN(wrHiN), .dtackN(dtackN)
  );

  bus_glue_top #(.ACK_DELAY(0)) dut0_i (
    .clk(clk), .rstN(rstN), .pageAddr(pageAddr), .asN(asN), .udsN(udsN),
    .ldsN(ldsN), .rdWrN(rdWrN), .romSelN(romSel0N), .ramSelN(ramSel0N),
    .ioSelN(ioSel0N), .rdLoN(rdLo0N), .rdHiN(rdHi0N), .wrLoN(wrLo0N),
    .wrHiN(wrHi0N), .dtackN(dtack0N)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Wait n rising edges, then sample 1 ns later
  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic idleBus();
    @(negedge clk);
    asN = 1'b1; udsN = 1'b1; ldsN = 1'b1; rdWrN = 1'b1;
    #1;
  endtask

  task automatic tReset();
    check("R10 dtack after reset", {7'b0, dtackN}, 8'd1);
    check("R3 selects idle after reset", {5'b0, romSelN, ramSelN, ioSelN}, 8'b111);
  endtask

  task automatic tDecode();
    logic [2:0] expSel;
    for (int pg = 0; pg < 8; pg++) begin
      @(negedge clk);
      pageAddr = 3'(pg); asN = 1'b0;
      #1;
      case (pg)
        0:       expSel = 3'b011;
        1, 2:    expSel = 3'b101;
        3:       expSel = 3'b110;
        default: expSel = 3'b111;
      endcase
      check(pg == 0 ? "R1 rom at page zero" : "R2 page decode",
            {5'b0, romSelN, ramSelN, ioSelN}, {5'b0, expSel});
      asN = 1'b1;
      #1;
      check("R3 selects off with asN high", {5'b0, romSelN, ramSelN, ioSelN}, 8'b111);
    end
    pageAddr = 3'd0;
  endtask

  task automatic tLanes();
    for (int v = 0; v < 8; v++) begin
      logic u, l, rw;
      {u, l, rw} = 3'(v);
      @(negedge clk);
      udsN = u; ldsN = l; rdWrN = rw; asN = 1'b0;
      #1;
      check("R4 read lane enables", {6'b0, rdHiN, rdLoN}, {6'b0, u | ~rw, l | ~rw});
      check("R5 write lane enables", {6'b0, wrHiN, wrLoN}, {6'b0, u | rw, l | rw});
    end
    idleBus();
  endtask

  task automatic tReadAck();
    @(negedge clk);
    pageAddr = 3'd0; asN = 1'b0; rdWrN = 1'b1; udsN = 1'b0; ldsN = 1'b0;
    #1;
    check("R6 no ack before any edge", {7'b0, dtackN}, 8'd1);
    edges(1);
    check("R6 zero-delay ack on first edge", {7'b0, dtack0N}, 8'd0);
    check("R6 delay 2 high after edge 1", {7'b0, dtackN}, 8'd1);
    edges(1);
    check("R6 delay 2 high after edge 2", {7'b0, dtackN}, 8'd1);
    edges(1);
    check("R6 delay 2 low after edge 3", {7'b0, dtackN}, 8'd0);
    @(negedge clk);
    #2;
    udsN = 1'b1; ldsN = 1'b1; asN = 1'b1;
    #1;
    check("R7 ack released without an edge", {6'b0, dtackN, dtack0N}, 8'b11);
    @(negedge clk);
    asN = 1'b0; ldsN = 1'b0;
    edges(2);
    check("R7 restart waits full delay", {7'b0, dtackN}, 8'd1);
    edges(1);
    check("R7 restart acks after full delay", {7'b0, dtackN}, 8'd0);
    idleBus();
  endtask

  task automatic tWriteEarly();
    @(negedge clk);
    pageAddr = 3'd1; asN = 1'b0; rdWrN = 1'b0;
    edges(2);
    check("R8 early write not yet acked", {7'b0, dtackN}, 8'd1);
    edges(1);
    check("R8 early write acked with strobes high", {7'b0, dtackN}, 8'd0);
    check("R5 write enables high with strobes high", {6'b0, wrHiN, wrLoN}, 8'b11);
    idleBus();
    pageAddr = 3'd0;
  endtask

  task automatic tReserved();
    @(negedge clk);
    pageAddr = 3'd5; asN = 1'b0; rdWrN = 1'b1; udsN = 1'b0; ldsN = 1'b0;
    edges(8);
    check("R9 reserved page stalls", {6'b0, dtackN, dtack0N}, 8'b11);
    idleBus();
    pageAddr = 3'd0;
  endtask

  initial begin
    #100000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    tReset();
    tDecode();
    tLanes();
    tReadAck();
    tWriteEarly();
    tReserved();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule